// File: doc/BRIEF.md
# PHY Initialization Completion Monitor

This block launches a PHY initialization or training run and then watches the PHY status word until the run ends. The host supplies a vector of step-enable bits and a one-cycle start request. The block writes that vector to the PHY command port with the trigger bit forced on. It then waits a fixed settling interval before it looks at status. It reports one of three outcomes: normal completion, a training error with its class, or a watchdog timeout.

Time is counted in microseconds. A prescaler turns the clock into a microsecond tick using a ticks-per-microsecond parameter. The settling interval and the watchdog limit are both given in microseconds. The error classes are kept after the run ends and are cleared only by the next accepted start. While a run is active, `busy_o` is high and further start requests have no effect.

Top module: `phyinit_watch`

## Requirements
- R1: When idle, a start request causes a single-cycle `phy_cmd_we_o` pulse in the next cycle. With that pulse, `phy_cmd_o` equals `step_i` with bit 0 (the trigger bit) forced to 1. `phy_cmd_o` keeps that value until the next accepted start.
- R2: The status word is ignored for SETTLE_US*TICKS_PER_US cycles after the start edge. The first status sample is taken at the edge that follows.
- R3: When a sampled status word has bit 0 (init done) set, `done_o` pulses for one cycle and `busy_o` falls in the same cycle.
- R4: Status bits 5 to 9 carry five error flags, in this order: gate training error, gate training intermittent error, drift error, read-valid training error and read-valid intermittent error. If any of them is set in a sample, polling stops with a `done_o` pulse. `err_o[i]` then holds status bit 5+i from that sample, until the next accepted start clears it.
- R5: If no stop condition has been sampled and the elapsed whole microseconds since the start edge exceed TIMEOUT_US, the run aborts. `timeout_o` is set and `busy_o` falls, with no `done_o` pulse. If a stop condition and the timeout fall in the same cycle, the status result takes priority.
- R6: A start request while `busy_o` is high is ignored. It produces no command write, leaves `phy_cmd_o` unchanged and does not change when the run ends.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle in which the run ends.
- R8: A synchronous active-low reset clears `busy_o`, `done_o`, `phy_cmd_we_o`, `phy_cmd_o`, `err_o` and `timeout_o`.
- R9: Status bits other than 0 and 5 to 9 have no effect on when a run ends or on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| step_i | input | STEP_W | Step-enable vector from the host |
| status_i | input | STAT_W | PHY status word |
| phy_cmd_o | output | STEP_W | Command vector written to the PHY |
| phy_cmd_we_o | output | 1 | One-cycle write strobe for `phy_cmd_o` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when polling ends on status |
| err_o | output | 5 | Sticky error classes captured at the stop |
| timeout_o | output | 1 | Sticky watchdog expiry flag |

## Verification
The bench holds the done bit high from the very first cycle after start. A design that sampled during the settling window would end the run early. The bench sets each error flag on its own and also sets several flags together with done. A design that mapped the flags wrongly, or that treated an error-only word as still running, would report the wrong class or end up in a timeout. The bench runs the watchdog to expiry with a silent status word and checks the exact cycle of expiry, which exposes off-by-one errors in the microsecond count. It also fires a second start in the middle of a run with a different step vector, and raises unrelated status bits; any reaction to either one changes the command output or the end cycle.

// File: rtl/phyinit_pkg.sv
// Shared constants and types for the PHY init completion monitor.
// Assumes the PHY status layout: done at bit 0, five error flags at 5..9.
package phyinit_pkg;
    localparam int TRIG_POS = 0;   // trigger bit in the command vector
    localparam int DONE_POS = 0;   // init-done bit in the status word
    localparam int ERR_LSB  = 5;   // lowest error flag in the status word
    localparam int NUM_ERR  = 5;   // number of error classes

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_POLL   = 2'd2
    } run_state_t;
endpackage

// File: rtl/phyinit_ustick.sv
// Microsecond time base: a prescaler of TICKS_PER_US cycles feeding an
// elapsed-microsecond counter. Assumes clear is held while no run is active.
module phyinit_ustick #(
    parameter int TICKS_PER_US = 125,
    parameter int US_W         = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic            tick,
    output logic [US_W-1:0] us_cnt
);
    localparam int PC_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    logic [PC_W-1:0] pc;

    // Tick marks the last clock of each microsecond.
    assign tick = (pc == PC_W'(TICKS_PER_US - 1));

    // Advance prescaler and microsecond count; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pc     <= '0;
            us_cnt <= '0;
        end else if (tick) begin
            pc     <= '0;
            us_cnt <= us_cnt + 1'b1;
        end else begin
            pc     <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/phyinit_status_eval.sv
// Decodes the PHY status word into a done flag, the error class vector
// and a combined stop condition. Purely combinational.
module phyinit_status_eval
    import phyinit_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0]  status,
    output logic               done_hit,
    output logic [NUM_ERR-1:0] err_vec,
    output logic               stop_hit
);
    // Pick out each error flag at its fixed position.
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        assign err_vec[i] = status[ERR_LSB + i];
    end

    // Done flag and stop condition.
    assign done_hit = status[DONE_POS];
    assign stop_hit = done_hit | (|err_vec);
endmodule

// File: rtl/phyinit_watch.sv
// Top of the PHY init completion monitor. Writes the step vector with the
// trigger bit, waits SETTLE_US, then samples status every cycle until done,
// an error flag, or TIMEOUT_US elapse. Assumes 1 <= SETTLE_US < TIMEOUT_US.
module phyinit_watch
    import phyinit_pkg::*;
#(
    parameter int STEP_W       = 32,
    parameter int STAT_W       = 32,
    parameter int TICKS_PER_US = 125,
    parameter int SETTLE_US    = 10,
    parameter int TIMEOUT_US   = 1000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STEP_W-1:0]  step_i,
    input  logic [STAT_W-1:0]  status_i,
    output logic [STEP_W-1:0]  phy_cmd_o,
    output logic               phy_cmd_we_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [NUM_ERR-1:0] err_o,
    output logic               timeout_o
);
    localparam int US_W = $clog2(TIMEOUT_US + 2);
    localparam logic [STEP_W-1:0] TRIG_MASK = STEP_W'(1) << TRIG_POS;

    run_state_t         state;
    logic               us_tick;
    logic [US_W-1:0]    us_cnt;
    logic               done_hit;
    logic               stop_hit;
    logic [NUM_ERR-1:0] err_vec;
    logic               settle_end;
    logic               overtime;

    phyinit_ustick #(
        .TICKS_PER_US (TICKS_PER_US),
        .US_W         (US_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state == ST_IDLE),
        .tick   (us_tick),
        .us_cnt (us_cnt)
    );

    phyinit_status_eval #(
        .STAT_W (STAT_W)
    ) u_eval (
        .status   (status_i),
        .done_hit (done_hit),
        .err_vec  (err_vec),
        .stop_hit (stop_hit)
    );

    // Settling ends when the microsecond count reaches SETTLE_US.
    assign settle_end = us_tick && (us_cnt == US_W'(SETTLE_US - 1));
    // Watchdog condition: elapsed microseconds beyond the limit.
    assign overtime   = (us_cnt > US_W'(TIMEOUT_US));
    assign busy_o     = (state != ST_IDLE);

    // Run sequencer: launch, settle, poll and capture the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            phy_cmd_o    <= '0;
            phy_cmd_we_o <= 1'b0;
            done_o       <= 1'b0;
            err_o        <= '0;
            timeout_o    <= 1'b0;
        end else begin
            phy_cmd_we_o <= 1'b0;
            done_o       <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        phy_cmd_o    <= step_i | TRIG_MASK;
                        phy_cmd_we_o <= 1'b1;
                        err_o        <= '0;
                        timeout_o    <= 1'b0;
                        state        <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_end) begin
                        state <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (stop_hit) begin
                        done_o <= 1'b1;
                        err_o  <= err_vec;
                        state  <= ST_IDLE;
                    end else if (overtime) begin
                        timeout_o <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phyinit_watch_chk.sv
// Property checker for phyinit_watch, bound into every instance.
// Tracks cycles since the command strobe to check the settling window.
module phyinit_watch_chk #(
    parameter int STEP_W       = 32,
    parameter int TICKS_PER_US = 125,
    parameter int SETTLE_US    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [STEP_W-1:0] phy_cmd_o,
    input logic              phy_cmd_we_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [4:0]        err_o,
    input logic              timeout_o
);
    localparam int SETTLE_CYC = SETTLE_US * TICKS_PER_US;
    localparam int CW         = $clog2(SETTLE_CYC + 3) + 1;
    localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYC + 2);

    logic [CW-1:0] since_we;

    // Cycles since the last command strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_we <= CMAX;
        else if (phy_cmd_we_o)    since_we <= CW'(1);
        else if (since_we != CMAX) since_we <= since_we + 1'b1;
    end

    assert_we_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd_we_o |=> !phy_cmd_we_o);
    assert_trig_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd_we_o |-> phy_cmd_o[0]);
    assert_no_early_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_we >= CW'(SETTLE_CYC + 1)));
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));
    assert_timeout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !busy_o);
    assert_timeout_no_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_o && done_o));
    assert_busy_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> phy_cmd_we_o);
    assert_cmd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (phy_cmd_we_o || $stable(phy_cmd_o)));
endmodule

bind phyinit_watch phyinit_watch_chk #(
    .STEP_W       (STEP_W),
    .TICKS_PER_US (TICKS_PER_US),
    .SETTLE_US    (SETTLE_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .phy_cmd_o    (phy_cmd_o),
    .phy_cmd_we_o (phy_cmd_we_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .timeout_o    (timeout_o)
);

// File: tb/tb_phyinit_watch.sv
// Bench for phyinit_watch: a behavioural reference model runs on every
// clock and all outputs are compared against it at the falling edge.
module tb_phyinit_watch;
    localparam int STEP_W = 16;
    localparam int STAT_W = 16;
    localparam int TPU    = 4;
    localparam int SETT   = 3;
    localparam int TMO    = 20;
    localparam int SCYC   = SETT * TPU;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [STEP_W-1:0] step_i = '0;
    logic [STAT_W-1:0] status_i = '0;
    logic [STEP_W-1:0] phy_cmd_o;
    logic              phy_cmd_we_o;
    logic              busy_o;
    logic              done_o;
    logic [4:0]        err_o;
    logic              timeout_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    phyinit_watch #(
        .STEP_W (STEP_W), .STAT_W (STAT_W), .TICKS_PER_US (TPU),
        .SETTLE_US (SETT), .TIMEOUT_US (TMO)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .step_i (step_i),
        .status_i (status_i), .phy_cmd_o (phy_cmd_o),
        .phy_cmd_we_o (phy_cmd_we_o), .busy_o (busy_o), .done_o (done_o),
        .err_o (err_o), .timeout_o (timeout_o)
    );

    // Reference model state.
    bit              m_busy, m_we, m_done, m_to;
    bit [STEP_W-1:0] m_cmd;
    bit [4:0]        m_err;
    int              k;

    // Behavioural model: cycles since launch decide settle, poll and timeout.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_we = 0; m_done = 0; m_to = 0; m_cmd = '0; m_err = '0; k = 0;
        end else begin
            m_we = 0; m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; k = 0; m_cmd = step_i | 16'h0001;
                    m_we = 1; m_err = '0; m_to = 0;
                end
            end else begin
                k = k + 1;
                if (k >= SCYC + 1) begin
                    if (status_i[0] || (status_i[9:5] != 5'b0)) begin
                        m_done = 1; m_err = status_i[9:5]; m_busy = 0;
                    end else if ((k - 1) / TPU > TMO) begin
                        m_to = 1; m_busy = 0;
                    end
                end
            end
        end
    end

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cmp("R1 cmd_we", 32'(phy_cmd_we_o), 32'(m_we));
        cmp("R1 cmd", 32'(phy_cmd_o), 32'(m_cmd));
        cmp("R7 busy", 32'(busy_o), 32'(m_busy));
        cmp("R3 done", 32'(done_o), 32'(m_done));
        cmp("R4 err", 32'(err_o), 32'(m_err));
        cmp("R5 timeout", 32'(timeout_o), 32'(m_to));
    end

    task automatic pulse_start(input logic [STEP_W-1:0] s);
        @(negedge clk); start_i = 1'b1; step_i = s;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
        @(negedge clk); status_i = '0;
        repeat (3) @(negedge clk);
    endtask

    // One run: launch, then after dly cycles present the status word.
    task automatic run(input logic [STEP_W-1:0] s, input int dly, input logic [STAT_W-1:0] st);
        pulse_start(s);
        repeat (dly) @(negedge clk);
        status_i = st;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state checked explicitly.
        cmp("R8 busy", 32'(busy_o), 32'd0);
        cmp("R8 err", 32'(err_o), 32'd0);
        cmp("R8 timeout", 32'(timeout_o), 32'd0);
        rst_n = 1'b1;
        // R1 R3: plain completion, trigger bit added to an even vector.
        run(16'h00A0, 30, 16'h0001);
        // R2: done high from the start, must wait out settling.
        run(16'h0F00, 0, 16'h0001);
        // R4: each error class on its own.
        for (int e = 0; e < 5; e++) run(16'h0002, 20, 16'(1 << (5 + e)));
        // R4: several errors together with done.
        run(16'h1234, 25, 16'h0321);
        // R5: silent status runs into the watchdog.
        run(16'h0004, 0, 16'h0000);
        // R9: unrelated status bits, then timeout.
        run(16'h0008, 0, 16'hFC1E);
        // R6: second start mid-run with another vector.
        pulse_start(16'h5550);
        repeat (5) @(negedge clk);
        pulse_start(16'hAAAA);
        repeat (10) @(negedge clk);
        status_i = 16'h0001;
        wait_idle();
        // R4: error vector held idle, then cleared by the next start.
        repeat (5) @(negedge clk);
        run(16'h0010, 40, 16'h0001);
        // R8: reset during a run.
        pulse_start(16'h0020);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(negedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule